// File: doc/BRIEF.md
# Wait-State Bus Register Subordinate

This block is a subordinate on an AHB-Lite bus. It holds a small word-organised register file. Each transfer has two overlapping phases. In the address phase the block records the target word, the direction and the byte lanes. In the data phase that follows, it either returns the addressed word or merges the write data into it. A build-time count of wait states stretches every data phase. During those cycles the block drives its ready output low, and the manager holds its next address on the bus until ready returns high.

The block is meant to sit behind an address decoder and a response multiplexor, alongside other subordinates. Its ready input is the bus-wide ready, so it starts a new transfer only when the bus as a whole is advancing. With zero wait states, transfers follow one another on every clock. A write followed at once by a read of the same word returns the newly written value.

Top module: `ahbl_wait_sub`

## Requirements
- R1: After reset, every word of the register file reads zero, `readyout_o` is high, `resp_o` is 0 and `rdata_o` is zero.
- R2: A transfer is recorded only on a rising clock edge where `sel_i`, `ready_i` and `trans_i[1]` are all high. An IDLE type (`trans_i` = 2'b00), or any cycle with `sel_i` low, leaves the storage unchanged and leaves `readyout_o` high.
- R3: After a transfer is recorded, `readyout_o` is low for exactly WAIT_STATES cycles. It is high in the cycle after those, which ends the data phase.
- R4: For a read (`wr_i` = 0 in the address phase), `rdata_o` carries the full addressed word in the cycle where `readyout_o` is high.
- R5: For a write (`wr_i` = 1 in the address phase), `wdata_i` is stored at the clock edge that ends the data phase. Values present on `wdata_i` during wait cycles have no effect.
- R6: `size_i` selects the write lanes: 0 writes one byte at lane `addr_i[1:0]`; 1 writes a halfword at lanes 1:0 or 3:2, chosen by `addr_i[1]`; 2 or more writes all four lanes. Lane n is bits 8n+7:8n.
- R7: `resp_o` is always 0 (OKAY).
- R8: With `ready_i` low, a selected NONSEQ request is not recorded, even if `readyout_o` is high.
- R9: An address phase presented in the final data cycle of the previous transfer is recorded at that cycle's closing edge. It then gets its own full data phase, and a read placed straight after a write to the same word returns the written data.
- R10: The word is selected by `addr_i[2 +: log2(DEPTH)]`. Higher address bits are ignored, so addresses that differ only there reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| sel_i | input | 1 | Decoder select for this subordinate |
| addr_i | input | ADDR_W | Byte address (address phase) |
| wr_i | input | 1 | 1 = write, 0 = read (address phase) |
| size_i | input | 3 | Access size code (address phase) |
| trans_i | input | 2 | Transfer type, IDLE 2'b00 or NONSEQ 2'b10 |
| ready_i | input | 1 | Bus-wide ready |
| wdata_i | input | DATA_W | Write data (data phase) |
| rdata_o | output | DATA_W | Read data, valid while readyout_o is high in a read data phase |
| readyout_o | output | 1 | Low while this block stretches a data phase |
| resp_o | output | 1 | Transfer response, always OKAY |

## Verification
A stuck or mis-loaded wait counter shows up as a wrong count of low `readyout_o` cycles. It can be seen within WAIT_STATES+1 cycles of the first recorded transfer, and the bench counts these cycles on every transfer. A wrong recorded index, direction or lane mask only shows at the ports when the affected word is read back. For that reason, random writes with mixed sizes are interleaved with reads of the same words, and back-to-back write-then-read pairs expose a write that lands one edge late. Spurious recording on IDLE, unselected or stalled cycles is caught by a held-low `readyout_o` in the next cycle and by a later read of the targeted word.

// File: rtl/ahbl_ws_pkg.sv
package ahbl_ws_pkg;

    localparam logic [1:0] TR_IDLE   = 2'b00;
    localparam logic [1:0] TR_NONSEQ = 2'b10;
    localparam logic       RESP_OKAY = 1'b0;

    typedef enum logic [2:0] {
        SZ_BYTE = 3'd0,
        SZ_HALF = 3'd1,
        SZ_WORD = 3'd2
    } size_e;

endpackage

// File: rtl/ahbl_ws_lanes.sv
module ahbl_ws_lanes #(
    parameter int BYTES = 4,
    localparam int OFF_W = $clog2(BYTES)
) (
    input  logic [OFF_W-1:0] addr_lo_i,
    input  logic [2:0]       size_i,
    output logic [BYTES-1:0] be_o
);

    int span;
    int base;

    always_comb begin
        if (int'(size_i) >= OFF_W) begin
            span = BYTES;
        end else begin
            span = 1 << size_i;
        end
        base = (int'(addr_lo_i) / span) * span;
        for (int b = 0; b < BYTES; b++) begin
            be_o[b] = (b >= base) && (b < base + span);
        end
    end

endmodule

// File: rtl/ahbl_ws_regfile.sv
module ahbl_ws_regfile #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int BYTES = DATA_W / 8,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [IDX_W-1:0]  widx_i,
    input  logic [BYTES-1:0]  be_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [IDX_W-1:0]  ridx_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] words_q [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                words_q[w] <= '0;
            end else if (we_i && (widx_i == IDX_W'(w))) begin
                for (int b = 0; b < BYTES; b++) begin
                    if (be_i[b]) begin
                        words_q[w][8*b +: 8] <= wdata_i[8*b +: 8];
                    end
                end
            end
        end
    end

    assign rdata_o = words_q[ridx_i];

endmodule

// File: rtl/ahbl_ws_waitctr.sv
module ahbl_ws_waitctr #(
    parameter int WAIT_STATES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic busy_o
);

    if (WAIT_STATES == 0) begin : g_nowait
        logic unused_ok;
        assign unused_ok = ^{clk, rst_n, load_i};
        assign busy_o    = 1'b0;
    end else begin : g_wait
        localparam int CW = $clog2(WAIT_STATES + 1);
        localparam logic [CW-1:0] CNT_MAX = CW'(WAIT_STATES);

        logic [CW-1:0] cnt_d, cnt_q;

        always_comb begin
            cnt_d = cnt_q;
            if (load_i) begin
                cnt_d = CNT_MAX;
            end else if (cnt_q != '0) begin
                cnt_d = cnt_q - 1'b1;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_d;
            end
        end

        assign busy_o = (cnt_q != '0);
    end

endmodule

// File: rtl/ahbl_wait_sub.sv
module ahbl_wait_sub
    import ahbl_ws_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter int WAIT_STATES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic [2:0]        size_i,
    input  logic [1:0]        trans_i,
    input  logic              ready_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              readyout_o,
    output logic              resp_o
);

    localparam int BYTES = DATA_W / 8;
    localparam int OFF_W = $clog2(BYTES);
    localparam int IDX_W = $clog2(DEPTH);

    typedef struct packed {
        logic             valid;
        logic             write;
        logic [IDX_W-1:0] idx;
        logic [BYTES-1:0] be;
    } phase_t;

    phase_t ph_d, ph_q;

    logic             capture;
    logic             busy;
    logic             done;
    logic [BYTES-1:0] lane_be;
    logic [DATA_W-1:0] word_rd;

    logic unused_ok;
    assign unused_ok = ^{addr_i[ADDR_W-1:OFF_W+IDX_W], trans_i[0]};

    assign capture = sel_i && ready_i && trans_i[1];
    assign done    = ph_q.valid && !busy;

    ahbl_ws_lanes #(.BYTES(BYTES)) lanes_i (
        .addr_lo_i (addr_i[OFF_W-1:0]),
        .size_i    (size_i),
        .be_o      (lane_be)
    );

    ahbl_ws_waitctr #(.WAIT_STATES(WAIT_STATES)) wait_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (capture),
        .busy_o (busy)
    );

    always_comb begin
        ph_d = ph_q;
        if (capture) begin
            ph_d.valid = 1'b1;
            ph_d.write = wr_i;
            ph_d.idx   = addr_i[OFF_W +: IDX_W];
            ph_d.be    = lane_be;
        end else if (done) begin
            ph_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q <= '0;
        end else begin
            ph_q <= ph_d;
        end
    end

    ahbl_ws_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (done && ph_q.write),
        .widx_i  (ph_q.idx),
        .be_i    (ph_q.be),
        .wdata_i (wdata_i),
        .ridx_i  (ph_q.idx),
        .rdata_o (word_rd)
    );

    assign rdata_o    = (ph_q.valid && !ph_q.write) ? word_rd : '0;
    assign readyout_o = !(ph_q.valid && busy);
    assign resp_o     = RESP_OKAY;

endmodule

// File: rtl/ahbl_ws_chk.sv
module ahbl_ws_chk #(
    parameter int WAIT_STATES = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       sel_i,
    input logic [1:0] trans_i,
    input logic       ready_i,
    input logic       readyout_o,
    input logic       resp_o
);

    localparam int CW = $clog2(WAIT_STATES + 2);
    localparam logic [CW-1:0] LOW_MAX = CW'(WAIT_STATES);
    localparam logic [CW-1:0] LOW_SAT = CW'(WAIT_STATES + 1);

    logic          req;
    logic [CW-1:0] low_run;

    assign req = sel_i && ready_i && trans_i[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!readyout_o) begin
            if (low_run != LOW_SAT) begin
                low_run <= low_run + 1'b1;
            end
        end else begin
            low_run <= '0;
        end
    end

    p_resp_okay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        resp_o == 1'b0);

    p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (readyout_o && !req) |=> readyout_o);

    p_stall_no_capture_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (readyout_o && !ready_i) |=> readyout_o);

    p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        low_run <= LOW_MAX);

    if (WAIT_STATES > 0) begin : g_ws
        p_wait_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
            req |=> !readyout_o);
    end else begin : g_zw
        p_wait_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
            req |=> readyout_o);
    end

endmodule

bind ahbl_wait_sub ahbl_ws_chk #(.WAIT_STATES(WAIT_STATES)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .trans_i    (trans_i),
    .ready_i    (ready_i),
    .readyout_o (readyout_o),
    .resp_o     (resp_o)
);

// File: tb/ahbl_wait_sub_tb_top.sv
module ahbl_wait_sub_tb_top;

    localparam int WAITS = 2;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_i = 1'b0;
    logic [31:0] addr_i = '0;
    logic        wr_i = 1'b0;
    logic [2:0]  size_i = 3'd2;
    logic [1:0]  trans_i = 2'b00;
    logic        ext_stall = 1'b0;
    logic        ready_i;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        readyout_o;
    logic        resp_o;

    int errors = 0;
    int checks = 0;
    logic [31:0] model [DEPTH];

    always #2 clk = ~clk;

    assign ready_i = ext_stall ? 1'b0 : readyout_o;

    ahbl_wait_sub #(.ADDR_W(32), .DATA_W(32), .DEPTH(DEPTH), .WAIT_STATES(WAITS)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .addr_i(addr_i), .wr_i(wr_i),
        .size_i(size_i), .trans_i(trans_i), .ready_i(ready_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .readyout_o(readyout_o), .resp_o(resp_o)
    );

    function automatic logic [3:0] f_be(input logic [1:0] lo, input logic [2:0] sz);
        if (sz == 3'd0) return 4'b0001 << lo;
        if (sz == 3'd1) return lo[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] f_merge(input logic [31:0] old, input logic [31:0] nw,
                                            input logic [3:0] be);
        logic [31:0] r = old;
        for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = nw[8*b +: 8];
        return r;
    endfunction

    function automatic int f_idx(input logic [31:0] a);
        return int'(a[5:2]);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // One transfer, idle bus around it; junk on wdata during wait cycles (R5)
    task automatic xfer(input bit wr, input logic [31:0] a, input logic [2:0] sz,
                        input logic [31:0] wd);
        int waits = 0;
        @(negedge clk);
        sel_i = 1'b1; trans_i = 2'b10; wr_i = wr; addr_i = a; size_i = sz;
        wdata_i = $urandom;
        @(negedge clk);
        sel_i = 1'b0; trans_i = 2'b10; addr_i = $urandom; wr_i = 1'b1;
        while (!readyout_o) begin
            waits++;
            wdata_i = ~wd;
            @(negedge clk);
        end
        wdata_i = wd;
        chk(waits == WAITS, "R3 wait length", 32'(waits), 32'(WAITS));
        chk(resp_o == 1'b0, "R7 response", 32'(resp_o), 32'd0);
        if (wr) begin
            model[f_idx(a)] = f_merge(model[f_idx(a)], wd, f_be(a[1:0], sz));
        end else begin
            chk(rdata_o == model[f_idx(a)], "R4/R5/R6/R10 read data", rdata_o,
                model[f_idx(a)]);
        end
    endtask

    // Write then read of same word, read address phase in the write's last cycle (R9)
    task automatic pipe_wr_rd(input logic [31:0] a, input logic [31:0] d);
        int waits = 0;
        @(negedge clk);
        sel_i = 1'b1; trans_i = 2'b10; wr_i = 1'b1; addr_i = a; size_i = 3'd2;
        @(negedge clk);
        sel_i = 1'b0; trans_i = 2'b00;
        while (!readyout_o) @(negedge clk);
        wdata_i = d;
        sel_i = 1'b1; trans_i = 2'b10; wr_i = 1'b0; addr_i = a; size_i = 3'd2;
        model[f_idx(a)] = d;
        @(negedge clk);
        sel_i = 1'b0; trans_i = 2'b00;
        while (!readyout_o) begin
            waits++;
            @(negedge clk);
        end
        chk(waits == WAITS, "R9 pipelined data phase length", 32'(waits), 32'(WAITS));
        chk(rdata_o == d, "R9 read after write", rdata_o, d);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(readyout_o == 1'b1, "R1 readyout in reset", 32'(readyout_o), 32'd1);
        chk(resp_o == 1'b0, "R1 resp in reset", 32'(resp_o), 32'd0);
        chk(rdata_o == '0, "R1 rdata in reset", rdata_o, 32'd0);
        rst_n = 1'b1;
        xfer(1'b0, 32'h0000_0000, 3'd2, '0);
        xfer(1'b0, 32'h0000_003C, 3'd2, '0);

        // R6 directed lanes
        xfer(1'b1, 32'h0000_0010, 3'd2, 32'h1122_3344);
        xfer(1'b1, 32'h0000_0013, 3'd0, 32'hAA00_0000);
        xfer(1'b1, 32'h0000_0010, 3'd1, 32'h0000_BEEF);
        xfer(1'b0, 32'h0000_0010, 3'd2, '0);
        chk(model[4] == 32'hAA22_BEEF, "R6 lane model", model[4], 32'hAA22_BEEF);

        // R10 alias through upper address bits
        xfer(1'b1, 32'h0000_0024, 3'd2, 32'hCAFE_F00D);
        xfer(1'b0, 32'h1234_5664, 3'd2, '0);

        // R2: IDLE while selected and unselected NONSEQ have no effect
        @(negedge clk);
        sel_i = 1'b1; trans_i = 2'b00; wr_i = 1'b1; addr_i = 32'h10; wdata_i = '1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(readyout_o == 1'b1, "R2 idle ready", 32'(readyout_o), 32'd1);
        end
        sel_i = 1'b0; trans_i = 2'b10;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(readyout_o == 1'b1, "R2 unselected ready", 32'(readyout_o), 32'd1);
        end
        trans_i = 2'b00;
        xfer(1'b0, 32'h0000_0010, 3'd2, '0);

        // R8: selected NONSEQ with bus ready low is not recorded
        @(negedge clk);
        ext_stall = 1'b1; sel_i = 1'b1; trans_i = 2'b10; wr_i = 1'b1;
        addr_i = 32'h24; size_i = 3'd2; wdata_i = 32'h0;
        @(negedge clk);
        ext_stall = 1'b0; sel_i = 1'b0; trans_i = 2'b00;
        for (int i = 0; i < 3; i++) begin
            chk(readyout_o == 1'b1, "R8 no capture under stall", 32'(readyout_o), 32'd1);
            @(negedge clk);
        end
        xfer(1'b0, 32'h0000_0024, 3'd2, '0);

        // R9 back-to-back
        pipe_wr_rd(32'h0000_0008, 32'h5A5A_A5A5);
        pipe_wr_rd(32'h0000_0038, 32'h0F0F_1234);

        // Random mix (R4, R5, R6, R10)
        for (int i = 0; i < 300; i++) begin
            logic [2:0]  sz = 3'($urandom % 3);
            logic [31:0] a  = $urandom;
            a = a & ~((32'd1 << sz) - 32'd1);
            xfer(1'($urandom % 2), a, sz, $urandom);
        end
        for (int i = 0; i < DEPTH; i++) xfer(1'b0, 32'(i * 4), 3'd2, '0);

        @(negedge clk);
        summary();
    end

endmodule